// File: doc/BRIEF.md
# Serially Programmable Flag Offset Register

This block stores the two distances that a FIFO's partial flags compare against: the almost-empty offset and the almost-full offset. It sits beside the flag logic and drives both values to it continuously. The FIFO memory, the pointers and the flag comparators live elsewhere.

During a master reset, a two-bit select input picks one of four preset offsets. The same preset goes into both offsets. After reset, software or a board controller can replace both offsets by shifting a 34-bit stream into a serial data pin. The stream is clocked by a dedicated serial clock and framed by a serial enable. A partial reset of the FIFO leaves the offsets as they are. Only a master reset brings back the presets.

Top module: `flag_offset_reg`

## Requirements
- R1: While `mrst` is high at a rising edge of `ser_clk`, both offsets load the preset chosen by `preset_sel`: code 00 gives 7, 01 gives 31, 10 gives 63, 11 gives 127. `load_done` is low in the following cycle.
- R2: Bits on `ser_in` are taken only at rising `ser_clk` edges where `ser_en` is high. Toggling `ser_in` while `ser_en` is low changes nothing.
- R3: In a sequence, the first 17 bits taken form `ae_offset` and the next 17 bits form `af_offset`. Each group is taken least significant bit first.
- R4: The edge that takes the 34th bit updates both outputs at once. At that same edge `load_done` rises, and it stays high for exactly one cycle.
- R5: Between a master reset and a completed sequence, and between two completed sequences, `ae_offset` and `af_offset` hold their values.
- R6: After the 34th bit, any further bits taken while `ser_en` stays high are ignored. This lasts until `ser_en` has been low for at least one edge.
- R7: If `ser_en` drops before 34 bits have been taken, the partial bits are discarded and the outputs are unchanged. The next sequence starts again at bit 0.
- R8: `prst` high at an edge leaves both offsets unchanged and aborts any sequence in progress. Shifting restarts at bit 0.
- R9: A master reset after serial programming restores the preset and aborts any sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial programming clock; all state changes on its rising edge |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| preset_sel | input | 2 | Preset choice sampled during master reset |
| ser_en | input | 1 | Serial enable framing a programming sequence |
| ser_in | input | 1 | Serial data bit |
| ae_offset | output | 17 | Active almost-empty offset |
| af_offset | output | 17 | Active almost-full offset |
| load_done | output | 1 | One-cycle pulse when a full sequence has been applied |

## Verification
The assertions check several rules on every cycle. After each master reset, the preset value must appear on both outputs. The outputs must not move in any cycle unless a load pulse or a master reset accounts for it. The load pulse must never last two cycles, and it must always follow a cycle in which the serial enable was high. Other behaviour needs the bench's scenarios, in which a behavioural model rebuilds the offsets from the queued bit stream: the bit order within and between the two offsets, the discarding of surplus bits, aborted and restarted sequences, and recovery after partial and master resets.

// File: rtl/flagofs_pkg.sv
package flagofs_pkg;
    // Preset choice codes; the numeric code is what the select pins carry.
    typedef enum logic [1:0] {
        SEL_SHORT = 2'b00,
        SEL_MID   = 2'b01,
        SEL_LONG  = 2'b10,
        SEL_MAX   = 2'b11
    } preset_sel_e;
endpackage

// File: rtl/flagofs_preset.sv
module flagofs_preset #(
    parameter int unsigned OFS_W    = 17,
    parameter int unsigned PRESET_0 = 7,
    parameter int unsigned PRESET_1 = 31,
    parameter int unsigned PRESET_2 = 63,
    parameter int unsigned PRESET_3 = 127
) (
    input  logic [1:0]       sel,
    output logic [OFS_W-1:0] value
);
    import flagofs_pkg::*;

    always_comb begin
        case (preset_sel_e'(sel))
            SEL_SHORT: value = OFS_W'(PRESET_0);
            SEL_MID:   value = OFS_W'(PRESET_1);
            SEL_LONG:  value = OFS_W'(PRESET_2);
            default:   value = OFS_W'(PRESET_3);
        endcase
    end
endmodule

// File: rtl/flagofs_shift.sv
module flagofs_shift #(
    parameter int unsigned NBITS = 34
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             ser_en,
    input  logic             ser_in,
    output logic [NBITS-1:0] word,
    output logic             take
);
    localparam int unsigned CNT_W = $clog2(NBITS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [NBITS-1:0] shadow;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if (mrst || prst || !ser_en) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < CNT_W'(NBITS)) begin
            st_d.shadow[st_q.cnt] = ser_in;
            st_d.cnt              = st_q.cnt + CNT_W'(1);
            take                  = (st_q.cnt == CNT_W'(NBITS - 1));
        end
        word = st_d.shadow;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/flag_offset_reg.sv
module flag_offset_reg #(
    parameter int unsigned OFS_W    = 17,
    parameter int unsigned PRESET_0 = 7,
    parameter int unsigned PRESET_1 = 31,
    parameter int unsigned PRESET_2 = 63,
    parameter int unsigned PRESET_3 = 127
) (
    input  logic             ser_clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic [1:0]       preset_sel,
    input  logic             ser_en,
    input  logic             ser_in,
    output logic [OFS_W-1:0] ae_offset,
    output logic [OFS_W-1:0] af_offset,
    output logic             load_done
);
    localparam int unsigned NBITS = 2 * OFS_W;

    typedef struct packed {
        logic [OFS_W-1:0] ae;
        logic [OFS_W-1:0] af;
        logic             done;
    } ofs_st_t;

    ofs_st_t          st_d, st_q;
    logic [OFS_W-1:0] preset_val;
    logic [NBITS-1:0] shift_word;
    logic             shift_take;

    flagofs_preset #(
        .OFS_W(OFS_W), .PRESET_0(PRESET_0), .PRESET_1(PRESET_1),
        .PRESET_2(PRESET_2), .PRESET_3(PRESET_3)
    ) u_preset (
        .sel   (preset_sel),
        .value (preset_val)
    );

    flagofs_shift #(.NBITS(NBITS)) u_shift (
        .clk    (ser_clk),
        .mrst   (mrst),
        .prst   (prst),
        .ser_en (ser_en),
        .ser_in (ser_in),
        .word   (shift_word),
        .take   (shift_take)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (mrst) begin
            st_d.ae = preset_val;
            st_d.af = preset_val;
        end else if (shift_take) begin
            st_d.ae   = shift_word[OFS_W-1:0];
            st_d.af   = shift_word[NBITS-1:OFS_W];
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge ser_clk) begin
        st_q <= st_d;
    end

    assign ae_offset = st_q.ae;
    assign af_offset = st_q.af;
    assign load_done = st_q.done;
endmodule

// File: rtl/flagofs_chk.sv
module flagofs_chk #(
    parameter int unsigned OFS_W    = 17,
    parameter int unsigned PRESET_0 = 7,
    parameter int unsigned PRESET_1 = 31,
    parameter int unsigned PRESET_2 = 63,
    parameter int unsigned PRESET_3 = 127
) (
    input logic             ser_clk,
    input logic             mrst,
    input logic [1:0]       preset_sel,
    input logic             ser_en,
    input logic [OFS_W-1:0] ae_offset,
    input logic [OFS_W-1:0] af_offset,
    input logic             load_done
);
    logic armed_q = 1'b0;

    always_ff @(posedge ser_clk) begin
        armed_q <= !mrst;
    end

    function automatic logic [OFS_W-1:0] expect_preset(input logic [1:0] s);
        case (s)
            2'b00:   return OFS_W'(PRESET_0);
            2'b01:   return OFS_W'(PRESET_1);
            2'b10:   return OFS_W'(PRESET_2);
            default: return OFS_W'(PRESET_3);
        endcase
    endfunction

    // R1
    reset_preset_chk: assert property (@(posedge ser_clk)
        mrst |=> (ae_offset == expect_preset($past(preset_sel)))
                 && (af_offset == ae_offset) && !load_done);

    // R4
    one_cycle_done_chk: assert property (@(posedge ser_clk) disable iff (mrst)
        load_done |=> !load_done);

    // R5
    hold_offsets_chk: assert property (@(posedge ser_clk) disable iff (mrst)
        (armed_q && !load_done) |-> ($stable(ae_offset) && $stable(af_offset)));

    // R2
    done_needs_enable_chk: assert property (@(posedge ser_clk) disable iff (mrst)
        (armed_q && load_done) |-> $past(ser_en));
endmodule

bind flag_offset_reg flagofs_chk #(
    .OFS_W(OFS_W), .PRESET_0(PRESET_0), .PRESET_1(PRESET_1),
    .PRESET_2(PRESET_2), .PRESET_3(PRESET_3)
) u_chk (
    .ser_clk    (ser_clk),
    .mrst       (mrst),
    .preset_sel (preset_sel),
    .ser_en     (ser_en),
    .ae_offset  (ae_offset),
    .af_offset  (af_offset),
    .load_done  (load_done)
);

// File: tb/tb_flag_offset_reg.sv
module tb_flag_offset_reg;
    logic        clk = 1'b0;
    logic        mrst = 1'b1;
    logic        prst = 1'b0;
    logic [1:0]  preset_sel = 2'b00;
    logic        ser_en = 1'b0;
    logic        ser_in = 1'b0;
    logic [16:0] ae_offset, af_offset;
    logic        load_done;

    int    n_checks = 0;
    int    n_fails  = 0;
    string phase    = "R1";

    // reference model state
    int          bitq[$];
    logic [16:0] m_ae = '0, m_af = '0;
    logic        m_done = 1'b0;

    always #10 clk = ~clk;

    flag_offset_reg dut (
        .ser_clk(clk), .mrst(mrst), .prst(prst), .preset_sel(preset_sel),
        .ser_en(ser_en), .ser_in(ser_in), .ae_offset(ae_offset),
        .af_offset(af_offset), .load_done(load_done)
    );

    function automatic logic [16:0] preset_of(input logic [1:0] s);
        case (s)
            2'b00:   return 17'd7;
            2'b01:   return 17'd31;
            2'b10:   return 17'd63;
            default: return 17'd127;
        endcase
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model, updated at each edge, compared 5 ns later
    always @(posedge clk) begin
        m_done = 1'b0;
        if (mrst) begin
            m_ae = preset_of(preset_sel);
            m_af = m_ae;
            bitq.delete();
        end else if (prst || !ser_en) begin
            bitq.delete();
        end else if (bitq.size() < 34) begin
            bitq.push_back(int'(ser_in));
            if (bitq.size() == 34) begin
                for (int i = 0; i < 17; i++) begin
                    m_ae[i] = bitq[i][0];
                    m_af[i] = bitq[17 + i][0];
                end
                m_done = 1'b1;
            end
        end
        #5;
        check({phase, " ae"}, ae_offset, m_ae);
        check({phase, " af"}, af_offset, m_af);
        check({phase, " done"}, {16'd0, load_done}, {16'd0, m_done});
    end

    task automatic send_word(input logic [16:0] ae, input logic [16:0] af, input int nbits);
        logic [33:0] w;
        w = {af, ae};
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            ser_en = 1'b1;
            ser_in = w[i];
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_en = 1'b0;
            ser_in = ~ser_in;
        end
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        mrst = 1'b1; preset_sel = s; ser_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        mrst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: each preset code
        phase = "R1";
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            idle(2);
            check("R1 direct", ae_offset, preset_of(2'(s)));
        end
        // R2: toggling data with enable low
        phase = "R2";
        idle(40);
        check("R2 direct", af_offset, 17'd127);
        // R3 / R4: a full sequence
        phase = "R3_R4";
        send_word(17'h1ABCD, 17'h00F0F, 34);
        idle(1);
        check("R3 direct ae", ae_offset, 17'h1ABCD);
        check("R3 direct af", af_offset, 17'h00F0F);
        idle(2);
        // R6: surplus bits with enable held
        phase = "R6";
        send_word(17'h00001, 17'h1FFFE, 34);
        send_word(17'h15555, 17'h0AAAA, 34);
        idle(1);
        check("R6 direct", ae_offset, 17'h00001);
        // R7: aborted sequence, then restart
        phase = "R7_R5";
        send_word(17'h1FFFF, 17'h1FFFF, 10);
        idle(3);
        check("R7 direct", af_offset, 17'h1FFFE);
        send_word(17'h0C3C3, 17'h13579, 34);
        idle(2);
        // R8: partial reset mid-sequence and while idle
        phase = "R8";
        send_word(17'h1F00F, 17'h00FF0, 20);
        @(negedge clk); prst = 1'b1; ser_in = 1'b1;
        @(negedge clk); prst = 1'b0;
        idle(2);
        check("R8 direct", ae_offset, 17'h0C3C3);
        send_word(17'h02468, 17'h1ACE0, 34);
        idle(1);
        @(negedge clk); prst = 1'b1;
        @(negedge clk); prst = 1'b0;
        idle(1);
        check("R8 kept", af_offset, 17'h1ACE0);
        // R9: master reset after programming, with a sequence in flight
        phase = "R9";
        send_word(17'h11111, 17'h02222, 12);
        do_reset(2'b10);
        idle(1);
        check("R9 direct", ae_offset, 17'd63);
        send_word(17'h00ABC, 17'h1DEF0, 34);
        idle(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule